// File: doc/BRIEF.md
# Row-Latched Self-Timed Write Controller

This block sits behind the serial protocol engine of a byte-wide non-volatile memory. A write transaction opens a page by handing over a 17-bit start address. The following data bytes are gathered into a one-row latch of 128 bytes. A column pointer tracks where each byte lands, and a mask records which columns hold a byte. When the protocol engine reports a stop condition in the slot right after a data-byte acknowledge, the latched row is committed. The commit is one self-timed programming cycle. During it the block drives a busy flag for a fixed, parameterised number of clocks and streams every loaded column out through a single memory write port.

The array itself lives outside the block, on the other side of the write port. A stop condition that arrives in any other slot throws the latched row away. So does a stop condition when nothing was loaded. Bytes that arrive while the write-inhibit flag is high are dropped. While the programming cycle runs, the block ignores every request from the protocol engine.

Top module: `page_write_ctl`

## Requirements
- R1: After reset `busy` and `memWe` are low.
- R2: A commit writes each loaded column exactly once, to address {row, column} with the byte latched for it. Writes go out in ascending column order, one per clock, starting in the first busy cycle.
- R3: `pageOpen` takes the row from `startAddr[16:7]` and the first column from `startAddr[6:0]`, and empties the latch. Each stored byte advances the column by one.
- R4: The column pointer wraps from 127 to 0, and the row bits stay unchanged.
- R5: A later byte stored to an already loaded column replaces the earlier one. Columns never loaded are not written.
- R6: A byte presented with `writeInhibit` high is not stored and does not advance the column.
- R7: A stop with `stopAtAckSlot` low starts no cycle and discards every latched byte.
- R8: `busy` rises in the clock after an accepted commit and stays high for exactly `PROG_CYCLES` cycles. When it falls the latch is empty.
- R9: While `busy` is high, `pageOpen`, `byteValid` and `stopEvt` have no effect.
- R10: A stop in the acknowledge slot with no loaded column starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pageOpen | input | 1 | Start of a write transaction; loads `startAddr` |
| startAddr | input | 17 | Start address: row in [16:7], column in [6:0] |
| byteValid | input | 1 | One data byte is present on `byteData` |
| byteData | input | 8 | Data byte |
| writeInhibit | input | 1 | When high, the current data byte is dropped |
| stopEvt | input | 1 | Stop condition seen on the bus |
| stopAtAckSlot | input | 1 | The stop fell in the slot right after a data-byte acknowledge |
| busy | output | 1 | Programming cycle in progress |
| memWe | output | 1 | Array write enable |
| memAddr | output | 17 | Array write address |
| memData | output | 8 | Array write data |

## Verification
A wrong latch mask or column pointer shows up during the next commit as an extra, missing or misplaced write on the memory port. It appears within 128 clocks of the commit, and the scoreboard matches each such write against a model of the page. A wrong cycle counter shows up as a busy pulse of the wrong length, and a leftover mask shows up as a spurious cycle on the next empty commit. Inputs poked during busy would either corrupt the drained data or change the row, so the pending writes reveal them.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef struct packed {
    logic loadAddr;    // open a new page: latch row/column, empty mask
    logic storeByte;   // store the present byte at the column pointer
    logic dropPage;    // empty the mask
    logic startDrain;  // restart the column scan
    logic draining;    // programming cycle in progress
  } pgwStrobe_t;

  typedef enum logic {
    PGW_IDLE = 1'b0,
    PGW_PROG = 1'b1
  } pgwState_t;
endpackage

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
  import pgw_pkg::*;
#(
  parameter int PROG_CYCLES = 500000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pageOpen,
  input  logic       byteValid,
  input  logic       writeInhibit,
  input  logic       stopEvt,
  input  logic       stopAtAckSlot,
  input  logic       pageLoaded,
  output pgwStrobe_t strobe,
  output logic       busy
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PROG_CYCLES - 1);

  pgwState_t state;
  logic [CNT_W-1:0] cycleCnt;
  logic acceptCommit;

  assign busy = (state == PGW_PROG);
  assign acceptCommit = (state == PGW_IDLE) && stopEvt && stopAtAckSlot && pageLoaded;

  always_comb begin
    strobe = '0;
    if (state == PGW_IDLE) begin
      if (pageOpen) begin
        strobe.loadAddr = 1'b1;
      end else if (stopEvt) begin
        strobe.startDrain = acceptCommit;
        strobe.dropPage   = !acceptCommit;
      end else begin
        strobe.storeByte = byteValid && !writeInhibit;
      end
    end else begin
      strobe.draining = 1'b1;
      strobe.dropPage = (cycleCnt == '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= PGW_IDLE;
      cycleCnt <= '0;
    end else begin
      case (state)
        PGW_IDLE: begin
          if (acceptCommit) begin
            state    <= PGW_PROG;
            cycleCnt <= CNT_LOAD;
          end
        end
        PGW_PROG: begin
          if (cycleCnt == '0) begin
            state <= PGW_IDLE;
          end else begin
            cycleCnt <= cycleCnt - 1'b1;
          end
        end
        default: state <= PGW_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pgw_datapath.sv
module pgw_datapath
  import pgw_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int COL_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  pgwStrobe_t        strobe,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [DATA_W-1:0] byteData,
  output logic              pageLoaded,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData
);
  localparam int ROW_W      = ADDR_W - COL_W;
  localparam int PAGE_BYTES = 1 << COL_W;

  logic [ROW_W-1:0]      rowReg;
  logic [COL_W-1:0]      colPtr;
  logic [PAGE_BYTES-1:0] loadMask;
  logic [DATA_W-1:0]     pageLatch [PAGE_BYTES];
  logic [COL_W:0]        scanIdx;
  logic [COL_W-1:0]      scanCol;
  logic                  scanDone;

  assign scanCol    = scanIdx[COL_W-1:0];
  assign scanDone   = scanIdx[COL_W];
  assign pageLoaded = |loadMask;

  // address registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowReg <= '0;
      colPtr <= '0;
    end else if (strobe.loadAddr) begin
      rowReg <= startAddr[ADDR_W-1:COL_W];
      colPtr <= startAddr[COL_W-1:0];
    end else if (strobe.storeByte) begin
      colPtr <= colPtr + 1'b1;  // wraps inside the row
    end
  end

  // per-column storage and loaded mask
  generate
    for (genvar c = 0; c < PAGE_BYTES; c++) begin : g_col
      logic hitCol;
      assign hitCol = strobe.storeByte && (colPtr == COL_W'(c));

      always_ff @(posedge clk) begin
        if (hitCol) pageLatch[c] <= byteData;
      end

      always_ff @(posedge clk) begin
        if (!rstN) begin
          loadMask[c] <= 1'b0;
        end else if (strobe.loadAddr || strobe.dropPage) begin
          loadMask[c] <= 1'b0;
        end else if (hitCol) begin
          loadMask[c] <= 1'b1;
        end
      end
    end
  endgenerate

  // column scan during the programming cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      scanIdx <= (COL_W+1)'(PAGE_BYTES);
    end else if (strobe.startDrain) begin
      scanIdx <= '0;
    end else if (strobe.draining && !scanDone) begin
      scanIdx <= scanIdx + 1'b1;
    end
  end

  assign memWe   = strobe.draining && !scanDone && loadMask[scanCol];
  assign memAddr = {rowReg, scanCol};
  assign memData = pageLatch[scanCol];
endmodule

// File: rtl/page_write_ctl.sv
module page_write_ctl
  import pgw_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 8,
  parameter int COL_W       = 7,
  parameter int PROG_CYCLES = 500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pageOpen,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteData,
  input  logic              writeInhibit,
  input  logic              stopEvt,
  input  logic              stopAtAckSlot,
  output logic              busy,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData
);
  pgwStrobe_t strobe;
  logic pageLoaded;

  pgw_ctrl #(.PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .pageOpen(pageOpen), .byteValid(byteValid),
    .writeInhibit(writeInhibit), .stopEvt(stopEvt), .stopAtAckSlot(stopAtAckSlot),
    .pageLoaded(pageLoaded), .strobe(strobe), .busy(busy)
  );

  pgw_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_W(COL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .startAddr(startAddr),
    .byteData(byteData), .pageLoaded(pageLoaded), .memWe(memWe),
    .memAddr(memAddr), .memData(memData)
  );
endmodule

// File: rtl/page_write_ctl_chk.sv
module page_write_ctl_chk #(
  parameter int ADDR_W      = 17,
  parameter int COL_W       = 7,
  parameter int PROG_CYCLES = 500000
) (
  input logic              clk,
  input logic              rstN,
  input logic              stopEvt,
  input logic              stopAtAckSlot,
  input logic              busy,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr
);
  int runLen;

  always_ff @(posedge clk) begin
    if (!rstN) runLen <= 0;
    else if (busy) runLen <= runLen + 1;
    else runLen <= 0;
  end

  // R2
  we_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);

  // R2
  col_ascending_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe)) |-> (memAddr[COL_W-1:0] > $past(memAddr[COL_W-1:0])));

  // R4
  row_const_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe)) |-> (memAddr[ADDR_W-1:COL_W] == $past(memAddr[ADDR_W-1:COL_W])));

  // R7
  start_after_slot_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopEvt && stopAtAckSlot));

  // R8
  busy_length_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runLen == PROG_CYCLES));
endmodule

bind page_write_ctl page_write_ctl_chk #(
  .ADDR_W(ADDR_W), .COL_W(COL_W), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
  .clk(clk), .rstN(rstN), .stopEvt(stopEvt), .stopAtAckSlot(stopAtAckSlot),
  .busy(busy), .memWe(memWe), .memAddr(memAddr)
);

// File: tb/tb_page_write_ctl.sv
module tb_page_write_ctl;
  localparam int P  = 150;
  localparam int NB = 128;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pageOpen = 1'b0;
  logic [16:0] startAddr = '0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        writeInhibit = 1'b0;
  logic        stopEvt = 1'b0;
  logic        stopAtAckSlot = 1'b0;
  logic        busy, memWe;
  logic [16:0] memAddr;
  logic [7:0]  memData;

  always #10 clk = ~clk;

  page_write_ctl #(.PROG_CYCLES(P)) dut (
    .clk(clk), .rstN(rstN), .pageOpen(pageOpen), .startAddr(startAddr),
    .byteValid(byteValid), .byteData(byteData), .writeInhibit(writeInhibit),
    .stopEvt(stopEvt), .stopAtAckSlot(stopAtAckSlot), .busy(busy),
    .memWe(memWe), .memAddr(memAddr), .memData(memData)
  );

  typedef struct { logic [16:0] a; logic [7:0] d; string tag; } wr_t;
  wr_t expQ[$];

  int checks = 0;
  int errors = 0;

  logic [7:0] mData [NB];
  bit         mLoaded [NB];
  logic [9:0] mRow;
  logic [6:0] mCol;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // monitor: compare each write against the scoreboard
  always @(negedge clk) begin
    if (rstN && memWe) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R9", "unexpected write addr", int'(memAddr), 0);
      end else begin
        wr_t w;
        w = expQ.pop_front();
        chk(memAddr == w.a, w.tag, "write addr", int'(memAddr), int'(w.a));
        chk(memData == w.d, w.tag, "write data", int'(memData), int'(w.d));
      end
    end
  end

  task automatic openPage(input logic [16:0] a);
    pageOpen = 1'b1; startAddr = a;
    @(negedge clk);
    pageOpen = 1'b0;
    mRow = a[16:7]; mCol = a[6:0];
    for (int c = 0; c < NB; c++) mLoaded[c] = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] d, input bit inh);
    byteValid = 1'b1; byteData = d; writeInhibit = inh;
    @(negedge clk);
    byteValid = 1'b0; writeInhibit = 1'b0;
    if (!inh) begin
      mData[mCol] = d; mLoaded[mCol] = 1'b1; mCol = mCol + 1'b1;
    end
  endtask

  task automatic stopBus(input bit slot, input string tag, output bit cyc);
    bit any = 1'b0;
    for (int c = 0; c < NB; c++) any |= mLoaded[c];
    cyc = slot && any;
    if (cyc) begin
      for (int c = 0; c < NB; c++)
        if (mLoaded[c]) expQ.push_back('{{mRow, 7'(c)}, mData[c], tag});
    end
    for (int c = 0; c < NB; c++) mLoaded[c] = 1'b0;
    stopEvt = 1'b1; stopAtAckSlot = slot;
    @(negedge clk);
    stopEvt = 1'b0; stopAtAckSlot = 1'b0;
  endtask

  task automatic waitIdle(input bit cyc, input bit poke, input string tag);
    if (cyc) begin
      int n = 0;
      while (busy && n < P + 10) begin
        if (poke && n < 3) begin
          // R9: requests during busy must be ignored
          pageOpen = 1'b1; startAddr = 17'h1FFFF; byteValid = 1'b1;
          byteData = 8'hEE; stopEvt = 1'b1; stopAtAckSlot = 1'b1;
        end else begin
          pageOpen = 1'b0; byteValid = 1'b0; stopEvt = 1'b0; stopAtAckSlot = 1'b0;
        end
        n++;
        @(negedge clk);
      end
      pageOpen = 1'b0; byteValid = 1'b0; stopEvt = 1'b0; stopAtAckSlot = 1'b0;
      chk(n == P, "R8", "busy length", n, P);
      chk(expQ.size() == 0, tag, "writes still pending", expQ.size(), 0);
    end else begin
      for (int k = 0; k < 4; k++) begin
        chk(!busy, tag, "busy after rejected commit", int'(busy), 0);
        @(negedge clk);
      end
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit cyc;
    repeat (3) @(negedge clk);
    chk(!busy, "R1", "busy in reset", int'(busy), 0);
    chk(!memWe, "R1", "memWe in reset", int'(memWe), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy, "R1", "busy after reset", int'(busy), 0);

    // R2: single byte
    openPage(17'h12345);
    sendByte(8'hA5, 1'b0);
    stopBus(1'b1, "R2", cyc);
    chk(busy == 1'b1, "R8", "busy after commit", int'(busy), 1);
    waitIdle(cyc, 1'b0, "R2");

    // R8: latch emptied at end of cycle, so an empty commit does nothing
    stopBus(1'b1, "R8", cyc);
    waitIdle(cyc, 1'b0, "R8");

    // R3 and R9: aligned page with pokes during busy
    openPage(17'h00400);
    for (int i = 0; i < 6; i++) sendByte(8'(8'h10 + i), 1'b0);
    stopBus(1'b1, "R3", cyc);
    waitIdle(cyc, 1'b1, "R9");

    // R4: wrap from column 125
    openPage(17'h1FF7D);
    for (int i = 0; i < 5; i++) sendByte(8'(8'h60 + i), 1'b0);
    stopBus(1'b1, "R4", cyc);
    waitIdle(cyc, 1'b0, "R4");

    // R5: 130 bytes, columns 0 and 1 overwritten
    openPage(17'h0A080);
    for (int i = 0; i < 130; i++) sendByte(8'(i) ^ 8'h3C, 1'b0);
    stopBus(1'b1, "R5", cyc);
    waitIdle(cyc, 1'b0, "R5");

    // R5: sparse page, only loaded columns written
    openPage(17'h05040);
    sendByte(8'h77, 1'b0);
    stopBus(1'b1, "R5", cyc);
    waitIdle(cyc, 1'b0, "R5");

    // R6: all bytes inhibited
    openPage(17'h03300);
    for (int i = 0; i < 3; i++) sendByte(8'hC0, 1'b1);
    stopBus(1'b1, "R6", cyc);
    waitIdle(cyc, 1'b0, "R6");

    // R6: inhibited byte leaves the column unchanged
    openPage(17'h0330A);
    sendByte(8'h01, 1'b0);
    sendByte(8'h02, 1'b1);
    sendByte(8'h03, 1'b0);
    stopBus(1'b1, "R6", cyc);
    waitIdle(cyc, 1'b0, "R6");

    // R7: stop outside the ack slot discards
    openPage(17'h04400);
    sendByte(8'h5A, 1'b0);
    sendByte(8'h5B, 1'b0);
    stopBus(1'b0, "R7", cyc);
    waitIdle(cyc, 1'b0, "R7");
    stopBus(1'b1, "R7", cyc);
    waitIdle(cyc, 1'b0, "R7");

    // R10: empty page commit
    openPage(17'h06600);
    stopBus(1'b1, "R10", cyc);
    waitIdle(cyc, 1'b0, "R10");

    chk(expQ.size() == 0, "R2", "final pending writes", expQ.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule